// File: doc/BRIEF.md
# Generation Pacing and Control Unit

This unit decides when a cellular grid simulation moves on to its next generation. A reloadable down-counter measures the generation period. When it reaches zero while the unit is running, the unit raises a one-cycle step request toward the grid update engine and reloads the counter. The reload value comes from one of eight preset periods. Each preset is twice as long as the one before it, starting from a base period given by a parameter.

Five single-cycle command inputs change this behaviour:

- a pause toggle, which switches between running and paused;
- faster and slower commands, which move through the presets and stop at either end;
- a single-step command, which produces exactly one generation and then leaves the unit paused;
- a randomize command, which raises a one-cycle request to refill the grid.

A 32-bit maximal-length LFSR runs on every clock. Its state is the random row data the update engine uses while it fills the grid. Keyboard decoding and the update engine itself sit outside this unit.

Top module: `gen_pacer`

## Requirements
- R1: A synchronous active-low reset leaves the unit in this state: `paused` = 0, `speed_sel` = INIT_SEL (default 3), `step_req` = 0, `rand_req` = 0, and `rand_row` = SEED.
- R2: While running with no commands, `step_req` is high for exactly one cycle in every BASE_PERIOD·2^`speed_sel` cycles. The counter counts down from that period minus one, fires at zero and reloads.
- R3: `cmd_faster` lowers `speed_sel` by one, which halves the period. `cmd_slower` raises it by one, which doubles the period. Both in the same cycle leave it unchanged. A new preset takes effect at the next reload.
- R4: `speed_sel` saturates. `cmd_faster` at 0 leaves it at 0, and `cmd_slower` at NUM_PRESETS-1 (default 7) leaves it at 7.
- R5: `cmd_pause` toggles `paused`. While paused the counter holds its value and `step_req` stays low except in answer to `cmd_step`. On resume, counting continues from the held value.
- R6: `cmd_step` makes `step_req` high on the next cycle, sets `paused` to 1 and reloads the counter. It takes priority over `cmd_pause` in the same cycle. If an expiry coincides with it, still only one pulse is produced.
- R7: `cmd_random` makes `rand_req` high for exactly the next cycle. `rand_req` is low otherwise.
- R8: `rand_row` advances every clock by a Galois right shift: next = (s >> 1) XOR (s[0] ? 32'h80200003 : 0). It is never zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cmd_pause | input | 1 | Toggle run/pause (one-cycle pulse) |
| cmd_faster | input | 1 | Select the next shorter period preset |
| cmd_slower | input | 1 | Select the next longer period preset |
| cmd_step | input | 1 | Advance one generation, then pause |
| cmd_random | input | 1 | Request a random refill of the grid |
| step_req | output | 1 | One-cycle request to compute the next generation |
| rand_req | output | 1 | One-cycle request to refill the grid |
| paused | output | 1 | 1 while the unit is paused |
| speed_sel | output | 3 | Current period preset index |
| rand_row | output | 32 | LFSR state used as random row data |

## Verification
The assertions assume that commands are sampled only outside reset and that they may arrive in any combination in any cycle, including pause, step and both speed commands together. The stimulus in the bench therefore combines directed sequences with a long stretch of independent, low-probability commands on all five inputs. That stretch reaches simultaneous commands, commands arriving at counter expiry, and both saturation limits, without relying on any spacing between commands. A behavioural reference model compares every output on every clock, and directed checks measure the period and the saturation points against values worked out by hand.

// File: rtl/gen_pacer_pkg.sv
// Package: shared helpers for the generation pacing unit.
// Assumes: periods fit in 32 bits before truncation to the counter width.
package gen_pacer_pkg;

    // Period in cycles of preset idx: base doubled idx times.
    function automatic int unsigned period_of(input int unsigned base, input int unsigned idx);
        return base << idx;
    endfunction

endpackage

// File: rtl/pace_speed_sel.sv
// Module: pace_speed_sel
// Holds the period preset index and presents the matching reload value.
// Assumes: faster/slower are single-cycle commands; the preset table is built
// at elaboration and every entry fits in CNT_W bits.
module pace_speed_sel
    import gen_pacer_pkg::*;
#(
    parameter int unsigned NUM_PRESETS = 8,
    parameter int unsigned INIT_SEL    = 3,
    parameter int unsigned BASE_PERIOD = 4,
    parameter int unsigned CNT_W       = 16,
    localparam int unsigned SEL_W      = $clog2(NUM_PRESETS)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             faster,
    input  logic             slower,
    output logic [SEL_W-1:0] sel,
    output logic [CNT_W-1:0] reload
);

    localparam logic [SEL_W-1:0] SEL_MAX  = SEL_W'(NUM_PRESETS - 1);
    localparam logic [SEL_W-1:0] SEL_INIT = SEL_W'(INIT_SEL);

    logic [CNT_W-1:0] preset_tbl [NUM_PRESETS];

    // Preset table: one reload value (period minus one) per index.
    for (genvar g = 0; g < NUM_PRESETS; g++) begin : g_preset
        assign preset_tbl[g] = CNT_W'(period_of(BASE_PERIOD, g) - 1);
    end

    // Index register: step by one, saturate at both ends, ignore conflicting commands.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sel <= SEL_INIT;
        end else if (faster && !slower && sel != '0) begin
            sel <= sel - 1'b1;
        end else if (slower && !faster && sel != SEL_MAX) begin
            sel <= sel + 1'b1;
        end
    end

    // Reload lookup for the current index.
    always_comb begin
        reload = preset_tbl[sel];
    end

endmodule

// File: rtl/pace_down_counter.sv
// Module: pace_down_counter
// Reloadable down-counter that measures one generation period.
// Assumes: load has priority over hold; the reload input is sampled only at
// load or expiry, so a preset change applies from the next reload.
module pace_down_counter #(
    parameter int unsigned CNT_W     = 16,
    parameter int unsigned RESET_VAL = 31
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             hold,
    input  logic             load,
    input  logic [CNT_W-1:0] reload,
    output logic [CNT_W-1:0] cnt,
    output logic             expire
);

    // Expiry flag: the counter sits at zero this cycle.
    always_comb begin
        expire = (cnt == '0);
    end

    // Count register: forced reload, hold, reload at zero, or decrement.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt <= CNT_W'(RESET_VAL);
        end else if (load) begin
            cnt <= reload;
        end else if (!hold) begin
            if (expire) begin
                cnt <= reload;
            end else begin
                cnt <= cnt - 1'b1;
            end
        end
    end

endmodule

// File: rtl/pace_ctrl.sv
// Module: pace_ctrl
// Run/pause state and the registered step and randomize request pulses.
// Assumes: commands are single-cycle; a step command wins over a pause toggle.
module pace_ctrl (
    input  logic clk,
    input  logic rst_n,
    input  logic cmd_pause,
    input  logic cmd_step,
    input  logic cmd_random,
    input  logic expire,
    output logic paused,
    output logic step_req,
    output logic rand_req
);

    // Run state: a step forces pause, otherwise a pause command toggles.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            paused <= 1'b0;
        end else if (cmd_step) begin
            paused <= 1'b1;
        end else if (cmd_pause) begin
            paused <= !paused;
        end
    end

    // Request pulses: one cycle after expiry while running, a step, or randomize.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            step_req <= 1'b0;
            rand_req <= 1'b0;
        end else begin
            step_req <= (expire && !paused) || cmd_step;
            rand_req <= cmd_random;
        end
    end

endmodule

// File: rtl/pace_lfsr.sv
// Module: pace_lfsr
// Free-running Galois LFSR whose state is the random row data.
// Assumes: SEED is nonzero and TAPS gives a maximal-length sequence, so the
// state never reaches zero.
module pace_lfsr #(
    parameter int unsigned      W    = 32,
    parameter logic [W-1:0]     TAPS = 32'h80200003,
    parameter logic [W-1:0]     SEED = 32'h1D2C3B4A
) (
    input  logic         clk,
    input  logic         rst_n,
    output logic [W-1:0] state
);

    logic [W-1:0] nxt;

    // Next state: shift right and fold in the taps when the low bit is set.
    always_comb begin
        nxt = (state >> 1) ^ ({W{state[0]}} & TAPS);
    end

    // State register, advanced every clock.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state <= SEED;
        end else begin
            state <= nxt;
        end
    end

endmodule

// File: rtl/gen_pacer.sv
// Module: gen_pacer (top)
// Paces grid generations: a preset-driven down-counter raises step requests,
// and single-cycle commands pause, step, retune speed or request a random fill.
// Assumes: all command inputs are synchronous to clk and one cycle wide.
module gen_pacer
    import gen_pacer_pkg::*;
#(
    parameter int unsigned  NUM_PRESETS = 8,
    parameter int unsigned  INIT_SEL    = 3,
    parameter int unsigned  BASE_PERIOD = 4,
    parameter int unsigned  CNT_W       = 16,
    parameter int unsigned  LFSR_W      = 32,
    parameter logic [LFSR_W-1:0] LFSR_TAPS = 32'h80200003,
    parameter logic [LFSR_W-1:0] SEED      = 32'h1D2C3B4A,
    localparam int unsigned SEL_W = $clog2(NUM_PRESETS)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cmd_pause,
    input  logic              cmd_faster,
    input  logic              cmd_slower,
    input  logic              cmd_step,
    input  logic              cmd_random,
    output logic              step_req,
    output logic              rand_req,
    output logic              paused,
    output logic [SEL_W-1:0]  speed_sel,
    output logic [LFSR_W-1:0] rand_row
);

    localparam int unsigned RESET_RELOAD = period_of(BASE_PERIOD, INIT_SEL) - 1;

    logic [CNT_W-1:0] reload_w;
    logic [CNT_W-1:0] cnt_q;
    logic             expire_w;

    pace_speed_sel #(
        .NUM_PRESETS (NUM_PRESETS),
        .INIT_SEL    (INIT_SEL),
        .BASE_PERIOD (BASE_PERIOD),
        .CNT_W       (CNT_W)
    ) u_speed (
        .clk    (clk),
        .rst_n  (rst_n),
        .faster (cmd_faster),
        .slower (cmd_slower),
        .sel    (speed_sel),
        .reload (reload_w)
    );

    pace_down_counter #(
        .CNT_W     (CNT_W),
        .RESET_VAL (RESET_RELOAD)
    ) u_count (
        .clk    (clk),
        .rst_n  (rst_n),
        .hold   (paused),
        .load   (cmd_step),
        .reload (reload_w),
        .cnt    (cnt_q),
        .expire (expire_w)
    );

    pace_ctrl u_ctrl (
        .clk        (clk),
        .rst_n      (rst_n),
        .cmd_pause  (cmd_pause),
        .cmd_step   (cmd_step),
        .cmd_random (cmd_random),
        .expire     (expire_w),
        .paused     (paused),
        .step_req   (step_req),
        .rand_req   (rand_req)
    );

    pace_lfsr #(
        .W    (LFSR_W),
        .TAPS (LFSR_TAPS),
        .SEED (SEED)
    ) u_lfsr (
        .clk   (clk),
        .rst_n (rst_n),
        .state (rand_row)
    );

endmodule

// File: rtl/gen_pacer_checker.sv
// Module: gen_pacer_checker
// Concurrent checks on the pacing unit, attached to every gen_pacer by bind.
// Assumes: commands may arrive in any combination in any cycle.
module gen_pacer_checker #(
    parameter int unsigned SEL_W  = 3,
    parameter int unsigned CNT_W  = 16,
    parameter int unsigned LFSR_W = 32
) (
    input logic              clk,
    input logic              rst_n,
    input logic              cmd_pause,
    input logic              cmd_faster,
    input logic              cmd_slower,
    input logic              cmd_step,
    input logic              cmd_random,
    input logic              step_req,
    input logic              rand_req,
    input logic              paused,
    input logic [SEL_W-1:0]  speed_sel,
    input logic [LFSR_W-1:0] rand_row,
    input logic [CNT_W-1:0]  cnt_q
);

    localparam logic [SEL_W-1:0] SEL_TOP = '1;

    // R5: while paused and not stepping, no step request follows
    p_paused_quiet_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (paused && !cmd_step) |=> !step_req);

    // R5: the counter holds while paused with no command touching it
    p_paused_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (paused && !cmd_step && !cmd_pause) |=> $stable(cnt_q));

    // R6: a step command yields a request and the paused state
    p_step_pauses_r6: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_step |=> (step_req && paused));

    // R4: speed-up saturates at index zero
    p_fast_sat_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (speed_sel == '0 && cmd_faster && !cmd_slower) |=> (speed_sel == '0));

    // R4: slow-down saturates at the top index
    p_slow_sat_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (speed_sel == SEL_TOP && cmd_slower && !cmd_faster) |=> (speed_sel == SEL_TOP));

    // R3: conflicting or absent speed commands leave the index unchanged
    p_sel_steady_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_faster == cmd_slower) |=> $stable(speed_sel));

    // R7: randomize request mirrors the command one cycle later
    p_rand_pulse_r7: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> (rand_req == $past(cmd_random)));

    // R8: random row data never reaches zero
    p_lfsr_nonzero_r8: assert property (@(posedge clk) disable iff (!rst_n)
        rand_row != '0);

    // R8: the row data changes every clock
    p_lfsr_moves_r8: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> !$stable(rand_row));

endmodule

bind gen_pacer gen_pacer_checker #(
    .SEL_W  (SEL_W),
    .CNT_W  (CNT_W),
    .LFSR_W (LFSR_W)
) u_checker (
    .clk        (clk),
    .rst_n      (rst_n),
    .cmd_pause  (cmd_pause),
    .cmd_faster (cmd_faster),
    .cmd_slower (cmd_slower),
    .cmd_step   (cmd_step),
    .cmd_random (cmd_random),
    .step_req   (step_req),
    .rand_req   (rand_req),
    .paused     (paused),
    .speed_sel  (speed_sel),
    .rand_row   (rand_row),
    .cnt_q      (cnt_q)
);

// File: tb/gen_pacer_tb_top.sv
`timescale 1ns/1ps
// Bench for gen_pacer: behavioural reference model compared on every clock,
// plus directed checks on reset, saturation, stepping and period length.
module gen_pacer_tb_top;

    localparam int unsigned BASE = 4;
    localparam logic [31:0] SEED = 32'h1D2C3B4A;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        c_pause = 1'b0, c_fast = 1'b0, c_slow = 1'b0, c_step = 1'b0, c_rand = 1'b0;
    logic        step_req, rand_req, paused;
    logic [2:0]  speed_sel;
    logic [31:0] rand_row;

    int total = 0;
    int bad = 0;
    int cycles = 0;

    // Reference model state
    bit          m_paused, m_step, m_rand;
    int          m_sel, m_cnt;
    logic [31:0] m_lfsr;

    always #2.5 clk = ~clk;

    gen_pacer dut_i (
        .clk        (clk),
        .rst_n      (rst_n),
        .cmd_pause  (c_pause),
        .cmd_faster (c_fast),
        .cmd_slower (c_slow),
        .cmd_step   (c_step),
        .cmd_random (c_rand),
        .step_req   (step_req),
        .rand_req   (rand_req),
        .paused     (paused),
        .speed_sel  (speed_sel),
        .rand_row   (rand_row)
    );

    // Reference model: requirement-level behaviour, updated at each rising edge.
    always @(posedge clk) begin
        cycles++;
        if (!rst_n) begin
            m_paused = 0; m_sel = 3; m_cnt = (BASE << 3) - 1;
            m_step = 0; m_rand = 0; m_lfsr = SEED;
        end else begin
            m_step = (!m_paused && m_cnt == 0) || c_step;
            m_rand = c_rand;
            if (c_step) m_cnt = (BASE << m_sel) - 1;
            else if (!m_paused) m_cnt = (m_cnt == 0) ? (BASE << m_sel) - 1 : m_cnt - 1;
            if (c_step) m_paused = 1;
            else if (c_pause) m_paused = !m_paused;
            if (c_fast && !c_slow && m_sel > 0) m_sel--;
            else if (c_slow && !c_fast && m_sel < 7) m_sel++;
            m_lfsr = (m_lfsr >> 1) ^ ({32{m_lfsr[0]}} & 32'h80200003);
        end
    end

    task automatic check(input bit ok, input string tag, input longint act, input longint exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic compare_all();
        check(step_req == m_step, "R2 step_req", step_req, m_step);
        check(paused == m_paused, "R5 paused", paused, m_paused);
        check(speed_sel == m_sel, "R3 speed_sel", speed_sel, m_sel);
        check(rand_req == m_rand, "R7 rand_req", rand_req, m_rand);
        check(rand_row == m_lfsr, "R8 rand_row", rand_row, m_lfsr);
        check(rand_row != 0, "R8 nonzero", rand_row, 1);
    endtask

    // One cycle: compare at the falling edge, then drive the next commands.
    task automatic tick(input bit p, input bit f, input bit s, input bit st, input bit r);
        @(negedge clk);
        compare_all();
        c_pause = p; c_fast = f; c_slow = s; c_step = st; c_rand = r;
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) tick(0, 0, 0, 0, 0);
    endtask

    // Watchdog: a hung run counts as a failure and still reports.
    initial begin
        wait (cycles > 150000);
        bad++;
        $display("FAIL watchdog actual=%0d expected=%0d", cycles, 150000);
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        int gap, seen, t0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        // R1: reset state
        check(paused == 0, "R1 paused", paused, 0);
        check(speed_sel == 3, "R1 speed_sel", speed_sel, 3);
        check(step_req == 0, "R1 step_req", step_req, 0);
        check(rand_req == 0, "R1 rand_req", rand_req, 0);
        check(rand_row == SEED, "R1 rand_row", rand_row, SEED);
        rst_n = 1'b1;

        // R2: free running at preset 3
        idle(100);
        // R4: faster saturates at 0
        for (int i = 0; i < 5; i++) tick(0, 1, 0, 0, 0);
        tick(0, 0, 0, 0, 0);
        check(speed_sel == 0, "R4 low saturation", speed_sel, 0);
        idle(40);
        // R4: slower saturates at 7
        for (int i = 0; i < 10; i++) tick(0, 0, 1, 0, 0);
        tick(0, 0, 0, 0, 0);
        check(speed_sel == 7, "R4 high saturation", speed_sel, 7);
        // R2: measured interval at preset 7 is 4*2^7 = 512 cycles
        seen = 0; t0 = 0; gap = 0;
        for (int i = 0; i < 1200 && seen < 2; i++) begin
            tick(0, 0, 0, 0, 0);
            if (step_req) begin
                if (seen == 1) gap = i - t0;
                t0 = i; seen++;
            end
        end
        check(gap == 512, "R2 period at preset 7", gap, 512);
        // R3: both speed commands together do nothing
        tick(0, 1, 1, 0, 0);
        tick(0, 0, 0, 0, 0);
        check(speed_sel == 7, "R3 conflicting speed", speed_sel, 7);
        for (int i = 0; i < 5; i++) tick(0, 1, 0, 0, 0);
        idle(20);
        // R5: pause, stay quiet, resume
        tick(1, 0, 0, 0, 0);
        seen = 0;
        for (int i = 0; i < 60; i++) begin
            tick(0, 0, 0, 0, 0);
            if (step_req && i > 0) seen++;
        end
        check(seen == 0, "R5 no pulse while paused", seen, 0);
        // R6: step while paused
        tick(0, 0, 0, 1, 0);
        tick(0, 0, 0, 0, 0);
        check(step_req == 1 && paused == 1, "R6 step while paused", {step_req, paused}, 3);
        tick(1, 0, 0, 0, 0);
        idle(30);
        // R6: step while running; step with pause in the same cycle
        tick(0, 0, 0, 1, 0);
        tick(0, 0, 0, 0, 0);
        check(paused == 1, "R6 step from running", paused, 1);
        idle(10);
        tick(1, 0, 0, 1, 0);
        tick(0, 0, 0, 0, 0);
        check(paused == 1, "R6 step beats pause", paused, 1);
        // R7: randomize pulse
        tick(0, 0, 0, 0, 1);
        tick(0, 0, 0, 0, 0);
        check(rand_req == 1, "R7 rand pulse", rand_req, 1);
        tick(1, 0, 0, 0, 0);
        // Random command stream
        for (int i = 0; i < 6000; i++)
            tick($urandom % 24 == 0, $urandom % 20 == 0, $urandom % 20 == 0,
                 $urandom % 40 == 0, $urandom % 16 == 0);
        idle(5);
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule